// File: doc/BRIEF.md
# Prescaled Serial Clock Generator

This block produces the serial clock of a two-wire bus master from a fast functional clock. A prescaler first divides the functional clock to form a slower module tick. The tick then paces two alternating phases, one with the clock line pulled low and one with it released. Each phase has its own programmed length, counted in ticks.

Each phase lasts its programmed count plus a base of seven ticks. That base is reduced by the prescaler setting, and the reduction never exceeds two ticks. With equal low and high counts the result is a symmetric clock. The prescaler is chosen so that the tick rate lands between roughly 7 and 12 MHz. Typical targets are 100 kHz and 400 kHz.

A device on the bus may hold the clock line low to slow the master down. When it does, the high phase stops counting until the line is sensed high. Settings may be rewritten at any time, but they only take effect at the next phase boundary. START and STOP generation and data sampling are handled elsewhere.

Top module: `scl_clk_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `scl_o` is 1 (released) and `tick` is 0.
- R2: When `en` is sampled low, from the next cycle `scl_o` is 1 and `tick` stays 0, and all counters return to zero. A later enable starts a complete low phase from the beginning.
- R3: While running, `tick` pulses for one cycle once every `psc`+1 functional clocks (with `psc`=0 it is high on every cycle). `scl_o` only changes on the cycle after a tick.
- R4: The low phase (`scl_o`=0) lasts `low_cnt` + 7 − min(`psc`,2) ticks, which is that number times (`psc`+1) clocks. Exactly that many ticks fall inside it.
- R5: The high phase (`scl_o`=1) lasts `high_cnt` + 7 − min(`psc`,2) ticks, provided `scl_in` is high throughout.
- R6: During the high phase, each tick that arrives while `scl_in` is 0 is not counted. The high phase is extended by one tick per such tick. The low phase is not affected by `scl_in`.
- R7: Changes to `psc`, `low_cnt` or `high_cnt` made in the middle of a phase do not alter that phase. They are captured at the next phase boundary, and also continuously while disabled.
- R8: After enable the first phase is always low, and the phases then alternate low, high, low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low releases the line and clears counters |
| psc | input | PSC_W | Prescaler setting; divides by this plus one |
| low_cnt | input | CNT_W | Low phase count |
| high_cnt | input | CNT_W | High phase count |
| scl_in | input | 1 | Sensed level of the clock line (already synchronous) |
| scl_o | output | 1 | Clock drive: 0 pulls low, 1 releases |
| tick | output | 1 | One-cycle module tick strobe |

## Verification
The design registers `scl_o`. A phase boundary taken at a clock edge therefore shows on the output in the cycle after that edge. An enable sampled at an edge gives `scl_o`=0 in the following cycle. A disable sampled at an edge gives `scl_o`=1 and `tick`=0 in the following cycle. The bench drives inputs and samples outputs on falling edges. It measures each phase as the number of consecutive falling-edge samples at one level, so every length check counts whole clock periods and the result does not depend on edge alignment. For the stretch case, the clock line is held low starting in the first cycle of the high phase, for exactly three prescaler periods. This makes the first three ticks of that phase the ones that are not counted.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // base ticks added to each programmed phase count
  localparam int unsigned PHASE_BASE   = 7;
  // largest amount the prescaler setting may trim from the base
  localparam int unsigned PSC_TRIM_MAX = 2;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);

  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == div);
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (at_top) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && at_top;

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int unsigned LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             hold,
  input  logic [LEN_W-1:0] len,
  output logic             done
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             adv;
  logic             last;

  always_comb begin
    adv   = tick && !hold;
    last  = (cnt_q == (len - 1'b1));
    done  = adv && last && !clear;
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = last ? '0 : (cnt_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W = 4,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             done,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [CNT_W-1:0] hi_in,
  output phase_e           phase,
  output logic [PSC_W-1:0] sh_psc,
  output logic [LEN_W-1:0] cur_len,
  output logic             scl_drv
);

  phase_e           phase_q, phase_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [LEN_W-1:0] lo_len_q, lo_len_d;
  logic [LEN_W-1:0] hi_len_q, hi_len_d;
  logic             scl_q, scl_d;
  logic             load;
  logic [1:0]       trim;
  logic [LEN_W-1:0] lo_len_in;
  logic [LEN_W-1:0] hi_len_in;

  always_comb begin
    trim      = (32'(psc_in) >= PSC_TRIM_MAX) ? 2'(PSC_TRIM_MAX) : 2'(psc_in);
    lo_len_in = LEN_W'(lo_in) + LEN_W'(PHASE_BASE) - LEN_W'(trim);
    hi_len_in = LEN_W'(hi_in) + LEN_W'(PHASE_BASE) - LEN_W'(trim);
  end

  always_comb begin
    phase_d = phase_q;
    if (!en) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE: phase_d = PH_LOW;
        PH_LOW:  if (done) phase_d = PH_HIGH;
        PH_HIGH: if (done) phase_d = PH_LOW;
        default: phase_d = PH_IDLE;
      endcase
    end
    load     = !en || (phase_q == PH_IDLE) || done;
    psc_d    = load ? psc_in    : psc_q;
    lo_len_d = load ? lo_len_in : lo_len_q;
    hi_len_d = load ? hi_len_in : hi_len_q;
    scl_d    = (phase_d != PH_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      psc_q    <= '0;
      lo_len_q <= '0;
      hi_len_q <= '0;
      scl_q    <= 1'b1;
    end else begin
      phase_q <= phase_d;
      scl_q   <= scl_d;
      if (load) begin
        psc_q    <= psc_d;
        lo_len_q <= lo_len_d;
        hi_len_q <= hi_len_d;
      end
    end
  end

  assign phase   = phase_q;
  assign sh_psc  = psc_q;
  assign cur_len = (phase_q == PH_HIGH) ? hi_len_q : lo_len_q;
  assign scl_drv = scl_q;

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_o,
  output logic             tick
);

  localparam int unsigned LEN_W = CNT_W + 1;

  phase_e           phase_q;
  logic [PSC_W-1:0] sh_psc;
  logic [LEN_W-1:0] cur_len;
  logic             run;
  logic             clear;
  logic             hold;
  logic             done;

  assign run   = (phase_q != PH_IDLE);
  assign clear = !en || !run;
  assign hold  = (phase_q == PH_HIGH) && !scl_in;

  scl_prescaler #(.PSC_W(PSC_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clear (clear),
    .div   (sh_psc),
    .tick  (tick)
  );

  scl_phase_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .tick  (tick),
    .hold  (hold),
    .len   (cur_len),
    .done  (done)
  );

  scl_phase_ctrl #(.PSC_W(PSC_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .done    (done),
    .psc_in  (psc),
    .lo_in   (low_cnt),
    .hi_in   (high_cnt),
    .phase   (phase_q),
    .sh_psc  (sh_psc),
    .cur_len (cur_len),
    .scl_drv (scl_o)
  );

endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W = 4,
  parameter int unsigned LEN_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             scl_in,
  input logic             scl_o,
  input logic             tick,
  input phase_e           phase,
  input logic [PSC_W-1:0] sh_psc,
  input logic [LEN_W-1:0] cur_len
);

  // R2: disabling releases the line and silences the tick
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !tick));

  // R3: while running, the line only toggles right after a tick
  assert_edge_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(en, 2) && (scl_o != $past(scl_o))) |-> $past(tick));

  // R6: a stretched high phase cannot end
  assert_stretch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase == PH_HIGH && !scl_in) |=> (phase == PH_HIGH));

  // R7: captured settings stay fixed inside a phase
  assert_shadow_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase == $past(phase))
      |-> (cur_len == $past(cur_len) && sh_psc == $past(sh_psc)));

  // R8: the first phase after enable is low
  assert_first_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && en) |=> (phase == PH_LOW));

endmodule

bind scl_clk_gen scl_clk_gen_chk #(.PSC_W(PSC_W), .LEN_W(LEN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .scl_in  (scl_in),
  .scl_o   (scl_o),
  .tick    (tick),
  .phase   (phase_q),
  .sh_psc  (sh_psc),
  .cur_len (cur_len)
);

// File: tb/tb_scl_clk_gen.sv
module tb_scl_clk_gen;

  localparam int unsigned PSC_W = 4;
  localparam int unsigned CNT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             en;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] high_cnt;
  logic             scl_in;
  logic             scl_o;
  logic             tick;
  logic             hold;

  int checks;
  int failures;
  int cycles;
  bit finished;

  assign scl_in = scl_o && !hold;

  scl_clk_gen #(.PSC_W(PSC_W), .CNT_W(CNT_W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .psc      (psc),
    .low_cnt  (low_cnt),
    .high_cnt (high_cnt),
    .scl_in   (scl_in),
    .scl_o    (scl_o),
    .tick     (tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      checks   = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=150000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ph_ticks(input int c, input int p);
    return c + 7 - ((p > 2) ? 2 : p);
  endfunction

  task automatic run_len(input logic lvl, output int n, output int nt);
    n = 0;
    nt = 0;
    while (scl_o === lvl && n < 4000) begin
      n++;
      if (tick) nt++;
      @(negedge clk);
    end
  endtask

  task automatic start_cfg(input int p, input int l, input int h);
    @(negedge clk);
    en = 1'b0; psc = PSC_W'(p); low_cnt = CNT_W'(l); high_cnt = CNT_W'(h);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int n, nt, n2, nt2, quiet;
    int plist[5] = '{0, 1, 2, 3, 6};
    int llist[2] = '{0, 5};
    int hlist[2] = '{0, 3};
    checks = 0; failures = 0; cycles = 0; finished = 1'b0;
    rst_n = 1'b0; en = 1'b0; hold = 1'b0;
    psc = '0; low_cnt = '0; high_cnt = '0;
    repeat (3) @(negedge clk);
    chk("R1 scl during reset", int'(scl_o), 1);
    chk("R1 tick during reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl after reset", int'(scl_o), 1);
    chk("R1 tick after reset", int'(tick), 0);

    // R4 R5 R3 R8: sweep of prescaler and phase counts
    foreach (plist[i]) begin
      foreach (llist[j]) begin
        foreach (hlist[k]) begin
          start_cfg(plist[i], llist[j], hlist[k]);
          chk("R8 first phase low", int'(scl_o), 0);
          run_len(1'b0, n, nt);
          chk("R4 low length clocks", n, ph_ticks(llist[j], plist[i]) * (plist[i] + 1));
          chk("R3 ticks in low phase", nt, ph_ticks(llist[j], plist[i]));
          run_len(1'b1, n, nt);
          chk("R5 high length clocks", n, ph_ticks(hlist[k], plist[i]) * (plist[i] + 1));
          run_len(1'b0, n, nt);
          chk("R8 second low length", n, ph_ticks(llist[j], plist[i]) * (plist[i] + 1));
        end
      end
    end

    // R6: stretch first three ticks of the high phase, psc=1, counts 0 -> 6 ticks
    start_cfg(1, 0, 0);
    run_len(1'b0, n, nt);
    chk("R6 low unaffected by line", n, 12);
    hold = 1'b1;
    n = 0;
    for (int c = 0; c < 6; c++) begin
      if (scl_o) n++;
      @(negedge clk);
    end
    hold = 1'b0;
    run_len(1'b1, n2, nt2);
    chk("R6 stretched high length", n + n2, 18);
    run_len(1'b0, n, nt);
    chk("R6 low after stretch", n, 12);

    // R7: mid-phase rewrite; psc=1 lo=2 hi=1 -> low 8 ticks x2
    start_cfg(1, 2, 1);
    repeat (5) @(negedge clk);
    low_cnt = 8'd6; psc = 4'd3;
    run_len(1'b0, n, nt);
    chk("R7 current low keeps old settings", n + 5, 16);
    run_len(1'b1, n, nt);
    chk("R7 next high uses new psc", n, 6 * 4);
    run_len(1'b0, n, nt);
    chk("R7 next low uses new count", n, 11 * 4);

    // R2: disable mid-phase, then re-enable
    start_cfg(1, 2, 2);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R2 line released when disabled", int'(scl_o), 1);
    quiet = 0;
    for (int c = 0; c < 6; c++) begin
      if (tick || !scl_o) quiet++;
      @(negedge clk);
    end
    chk("R2 no tick or drive while disabled", quiet, 0);
    en = 1'b1;
    @(negedge clk);
    run_len(1'b0, n, nt);
    chk("R2 fresh low after re-enable", n, 16);

    summary();
  end

endmodule